// File: doc/BRIEF.md
# Address Region Security Filter

The block sits beside up to four memory transaction ports (filters) and decides, one cycle after a transaction is presented, whether it may proceed. Each transaction carries an address, a secure/non-secure flag, a privilege flag, a direction and a small access ID. The filter looks the page address up in a set of programmable regions and applies the permissions of the region that wins.

Region 0 is a fixed background region that spans the whole address space, applies on every filter and only has programmable permissions. The other regions each have an inclusive base/top pair at 4 KB granularity and a bitmap naming the filters they apply to. Secure accesses are judged by a two-bit secure permission field. Non-secure accesses are judged by a per-ID read/write grant field. A denied access is reported according to a global action setting. The first denial on a filter is recorded for software, and a pending bit per filter drives an interrupt line.

Software programs the block through a simple word-addressed register port with a combinational read path.

Top module: `region_sec_filter`

## Requirements
- R1: After reset no response is valid, `irq_o` is low, the interrupt status (word 0x02) reads 0 and the action word (0x01) reads 0.
- R2: Word 0x00 is read-only and returns region count minus one in bits [4:0], address width minus one in bits [13:8] and filter count minus one in bits [25:24].
- R3: Region r (r ≥ 1) occupies words 0x40+8r .. 0x45+8r: +0/+1 base low/high, +2/+3 top low/high, +4 attributes, +5 ID grants. Base bits [11:0] read back as 0 and top bits [11:0] as 0xFFF; an address hits when base ≤ address ≤ top.
- R4: When several regions numbered 1 and up hit on a filter, the highest-numbered one decides; region 0 decides only when none hits.
- R5: Attribute bits [3:0] are a filter bitmap (bit f = filter f); a region whose bit for a filter is clear is invisible to that filter.
- R6: A secure access (`txn_ns_i`=0) is allowed when attribute bit 30 is set for a read or attribute bit 31 is set for a write.
- R7: A non-secure access with ID n is allowed when bit n (read) or bit 16+n (write) of the winning region's ID-grant word is set.
- R8: A response appears the cycle after the transaction. `resp_err_o` is set for a denied access when action bit 0 is set; action encodings are 0 none, 1 error, 2 interrupt, 3 both.
- R9: A denial with action bit 1 set sets that filter's bit in the interrupt status; `irq_o` is the OR of the status bits.
- R10: Writing word 0x03 clears each status bit whose data bit is 1 and leaves the others.
- R11: Each denial is recorded for its filter (words 0x10+4f: address low, address high, ID, control with bit 0 non-secure, bit 1 privileged, bit 2 write) unless that filter's status bit is pending, in which case the first record is held.
- R12: For region 0, writes to base, top and the filter bitmap are ignored; it reads back base 0, top all ones within the address width and all filters enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| txn_valid_i | input | NUM_FILTERS | Transaction present per filter |
| txn_addr_i | input | NUM_FILTERS*ADDR_W | Transaction address per filter |
| txn_ns_i | input | NUM_FILTERS | Non-secure flag per filter |
| txn_priv_i | input | NUM_FILTERS | Privileged flag per filter |
| txn_write_i | input | NUM_FILTERS | Write (1) or read (0) per filter |
| txn_id_i | input | NUM_FILTERS*ID_W | Access ID per filter |
| resp_valid_o | output | NUM_FILTERS | Decision valid per filter |
| resp_allow_o | output | NUM_FILTERS | Access permitted |
| resp_err_o | output | NUM_FILTERS | Bus error for a denied access |
| irq_o | output | 1 | Any filter has a pending denial |

## Verification
The assertions take for granted that a register write and a denial on the same filter are not meant to be ordered against each other beyond the stated set-wins rule, and that transaction inputs are stable across the sampling edge. The stimulus drives all inputs on the falling edge, never clears the status in a cycle that also carries a transaction, and keeps region bounds ordered with base below top so every expected decision is well defined.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  localparam logic [7:0] RA_BUILD  = 8'h00;
  localparam logic [7:0] RA_ACTION = 8'h01;
  localparam logic [7:0] RA_ISTAT  = 8'h02;
  localparam logic [7:0] RA_ICLR   = 8'h03;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_ERR  = 2'd1,
    ACT_IRQ  = 2'd2,
    ACT_BOTH = 2'd3
  } act_e;

  typedef struct packed {
    logic [63:0] addr;
    logic [15:0] id;
    logic        wr;
    logic        priv;
    logic        ns;
  } fail_rec_t;

  function automatic logic [63:0] put_word(logic [63:0] cur, logic hi, logic [31:0] w);
    logic [63:0] r;
    r = cur;
    if (hi) r[63:32] = w;
    else    r[31:0]  = w;
    return r;
  endfunction
endpackage

// File: rtl/rsf_region_regs.sv
module rsf_region_regs
  import rsf_pkg::*;
#(
  parameter int NUM_FILTERS = 4,
  parameter int NUM_REGIONS = 9,
  parameter int ADDR_W      = 40,
  localparam int PG_W       = ADDR_W - 12
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  we_i,
  input  logic [7:0]                            addr_i,
  input  logic [31:0]                           wdata_i,
  output logic [NUM_REGIONS-1:0][PG_W-1:0]      base_pg_o,
  output logic [NUM_REGIONS-1:0][PG_W-1:0]      top_pg_o,
  output logic [NUM_REGIONS-1:0][NUM_FILTERS-1:0] fen_o,
  output logic [NUM_REGIONS-1:0][1:0]           sec_o,
  output logic [NUM_REGIONS-1:0][31:0]          idp_o,
  output logic [1:0]                            action_o,
  output logic [31:0]                           rdata_o
);
  localparam logic [31:0] BUILD_WORD = (32'(NUM_FILTERS - 1) << 24) |
                                       (32'(ADDR_W - 1) << 8) |
                                       32'(NUM_REGIONS - 1);

  act_e action_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           action_q <= ACT_NONE;
    else if (we_i && addr_i == RA_ACTION)  action_q <= act_e'(wdata_i[1:0]);
  end
  assign action_o = action_q;

  logic [31:0] rd_r [NUM_REGIONS];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
    logic       sel;
    logic [1:0] sec_q;
    logic [31:0] idp_q;
    logic [63:0] full_b, full_t;

    assign sel = we_i && (addr_i[7:3] == 5'(8 + r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sec_q <= '0;
        idp_q <= '0;
      end else if (sel) begin
        if (addr_i[2:0] == 3'd4) sec_q <= wdata_i[31:30];
        if (addr_i[2:0] == 3'd5) idp_q <= wdata_i;
      end
    end
    assign sec_o[r] = sec_q;
    assign idp_o[r] = idp_q;

    if (r == 0) begin : g_bg
      // background region: bounds and filter map are fixed
      assign base_pg_o[r] = '0;
      assign top_pg_o[r]  = '1;
      assign fen_o[r]     = '1;
    end else begin : g_prog
      logic [PG_W-1:0]        base_q, top_q;
      logic [NUM_FILTERS-1:0] fen_q;
      logic [63:0]            nb, nt;

      assign nb = put_word(64'(base_q) << 12, addr_i[0], wdata_i);
      assign nt = put_word((64'(top_q) << 12) | 64'hFFF, addr_i[0], wdata_i);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          base_q <= '0;
          top_q  <= '0;
          fen_q  <= '0;
        end else if (sel) begin
          if (addr_i[2:1] == 2'b00) base_q <= nb[ADDR_W-1:12];
          if (addr_i[2:1] == 2'b01) top_q  <= nt[ADDR_W-1:12];
          if (addr_i[2:0] == 3'd4)  fen_q  <= wdata_i[NUM_FILTERS-1:0];
        end
      end
      assign base_pg_o[r] = base_q;
      assign top_pg_o[r]  = top_q;
      assign fen_o[r]     = fen_q;
    end

    assign full_b = 64'(base_pg_o[r]) << 12;
    assign full_t = (64'(top_pg_o[r]) << 12) | 64'hFFF;

    always_comb begin
      case (addr_i[2:0])
        3'd0:    rd_r[r] = full_b[31:0];
        3'd1:    rd_r[r] = full_b[63:32];
        3'd2:    rd_r[r] = full_t[31:0];
        3'd3:    rd_r[r] = full_t[63:32];
        3'd4:    rd_r[r] = {sec_o[r], 30'(fen_o[r])};
        3'd5:    rd_r[r] = idp_o[r];
        default: rd_r[r] = '0;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == RA_BUILD)  rdata_o = BUILD_WORD;
    if (addr_i == RA_ACTION) rdata_o = {30'b0, action_q};
    for (int r = 0; r < NUM_REGIONS; r++)
      if (addr_i[7:3] == 5'(8 + r)) rdata_o = rd_r[r];
  end
endmodule

// File: rtl/rsf_lookup.sv
module rsf_lookup #(
  parameter int NUM_FILTERS = 4,
  parameter int NUM_REGIONS = 9,
  parameter int ADDR_W      = 40,
  parameter int ID_W        = 4,
  parameter int FILT        = 0,
  localparam int PG_W       = ADDR_W - 12,
  localparam int RIDX_W     = $clog2(NUM_REGIONS)
) (
  input  logic [NUM_REGIONS-1:0][PG_W-1:0]        base_pg_i,
  input  logic [NUM_REGIONS-1:0][PG_W-1:0]        top_pg_i,
  input  logic [NUM_REGIONS-1:0][NUM_FILTERS-1:0] fen_i,
  input  logic [NUM_REGIONS-1:0][1:0]             sec_i,
  input  logic [NUM_REGIONS-1:0][31:0]            idp_i,
  input  logic [PG_W-1:0]                         addr_pg_i,
  input  logic                                    ns_i,
  input  logic                                    wr_i,
  input  logic [ID_W-1:0]                         id_i,
  output logic                                    allow_o
);
  logic [RIDX_W-1:0] hit;

  // later regions override earlier ones; region 0 is the fallback
  always_comb begin
    hit = '0;
    for (int r = 1; r < NUM_REGIONS; r++)
      if (fen_i[r][FILT] && addr_pg_i >= base_pg_i[r] && addr_pg_i <= top_pg_i[r])
        hit = RIDX_W'(r);
  end

  always_comb begin
    if (!ns_i) allow_o = wr_i ? sec_i[hit][1] : sec_i[hit][0];
    else       allow_o = idp_i[hit][{wr_i, 4'(id_i)}];
  end
endmodule

// File: rtl/rsf_fail_capture.sv
module rsf_fail_capture
  import rsf_pkg::*;
#(
  parameter int NUM_FILTERS = 4,
  parameter int ADDR_W      = 40,
  parameter int ID_W        = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_FILTERS-1:0]        deny_i,
  input  logic [1:0]                    action_i,
  input  logic [NUM_FILTERS-1:0]        clr_i,
  input  logic [NUM_FILTERS*ADDR_W-1:0] addr_i,
  input  logic [NUM_FILTERS*ID_W-1:0]   id_i,
  input  logic [NUM_FILTERS-1:0]        ns_i,
  input  logic [NUM_FILTERS-1:0]        priv_i,
  input  logic [NUM_FILTERS-1:0]        wr_i,
  input  logic [7:0]                    raddr_i,
  output logic [NUM_FILTERS-1:0]        status_o,
  output logic [31:0]                   rdata_o
);
  logic [NUM_FILTERS-1:0] status_q, set;
  fail_rec_t [NUM_FILTERS-1:0] rec_q;

  assign set = deny_i & {NUM_FILTERS{action_i[1]}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      rec_q    <= '0;
    end else begin
      status_q <= (status_q & ~clr_i) | set;  // a new denial wins over a clear
      for (int f = 0; f < NUM_FILTERS; f++)
        if (deny_i[f] && (!status_q[f] || clr_i[f]))
          rec_q[f] <= '{addr: 64'(addr_i[f*ADDR_W +: ADDR_W]),
                        id:   16'(id_i[f*ID_W +: ID_W]),
                        wr:   wr_i[f], priv: priv_i[f], ns: ns_i[f]};
    end
  end
  assign status_o = status_q;

  always_comb begin
    rdata_o = '0;
    if (raddr_i == RA_ISTAT) rdata_o = 32'(status_q);
    for (int f = 0; f < NUM_FILTERS; f++)
      if (raddr_i[7:4] == 4'h1 && raddr_i[3:2] == 2'(f))
        case (raddr_i[1:0])
          2'd0: rdata_o = rec_q[f].addr[31:0];
          2'd1: rdata_o = rec_q[f].addr[63:32];
          2'd2: rdata_o = 32'(rec_q[f].id);
          default: rdata_o = {29'b0, rec_q[f].wr, rec_q[f].priv, rec_q[f].ns};
        endcase
  end

  for (genvar f = 0; f < NUM_FILTERS; f++) begin : g_chk
    // R9: a pending bit only appears after an interrupting denial
    a_r9_set_needs_deny: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_q[f]) |-> $past(deny_i[f] && action_i[1]));
    // R11: record is frozen while pending and not cleared
    a_r11_hold_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(status_q[f]) && !$past(clr_i[f])) |-> $stable(rec_q[f]));
  end
endmodule

// File: rtl/region_sec_filter.sv
module region_sec_filter
  import rsf_pkg::*;
#(
  parameter int NUM_FILTERS = 4,
  parameter int NUM_REGIONS = 9,
  parameter int ADDR_W      = 40,
  parameter int ID_W        = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          reg_we_i,
  input  logic [7:0]                    reg_addr_i,
  input  logic [31:0]                   reg_wdata_i,
  output logic [31:0]                   reg_rdata_o,
  input  logic [NUM_FILTERS-1:0]        txn_valid_i,
  input  logic [NUM_FILTERS*ADDR_W-1:0] txn_addr_i,
  input  logic [NUM_FILTERS-1:0]        txn_ns_i,
  input  logic [NUM_FILTERS-1:0]        txn_priv_i,
  input  logic [NUM_FILTERS-1:0]        txn_write_i,
  input  logic [NUM_FILTERS*ID_W-1:0]   txn_id_i,
  output logic [NUM_FILTERS-1:0]        resp_valid_o,
  output logic [NUM_FILTERS-1:0]        resp_allow_o,
  output logic [NUM_FILTERS-1:0]        resp_err_o,
  output logic                          irq_o
);
  localparam int PG_W = ADDR_W - 12;

  logic [NUM_REGIONS-1:0][PG_W-1:0]        base_pg, top_pg;
  logic [NUM_REGIONS-1:0][NUM_FILTERS-1:0] fen;
  logic [NUM_REGIONS-1:0][1:0]             sec;
  logic [NUM_REGIONS-1:0][31:0]            idp;
  logic [1:0]                              action;
  logic [31:0]                             rd_reg, rd_fail;
  logic [NUM_FILTERS-1:0]                  allow_c, deny, clr, status;

  rsf_region_regs #(
    .NUM_FILTERS(NUM_FILTERS), .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .base_pg_o(base_pg), .top_pg_o(top_pg), .fen_o(fen), .sec_o(sec), .idp_o(idp),
    .action_o(action), .rdata_o(rd_reg)
  );

  for (genvar f = 0; f < NUM_FILTERS; f++) begin : g_filt
    rsf_lookup #(
      .NUM_FILTERS(NUM_FILTERS), .NUM_REGIONS(NUM_REGIONS),
      .ADDR_W(ADDR_W), .ID_W(ID_W), .FILT(f)
    ) u_lookup (
      .base_pg_i(base_pg), .top_pg_i(top_pg), .fen_i(fen), .sec_i(sec), .idp_i(idp),
      .addr_pg_i(txn_addr_i[f*ADDR_W+12 +: PG_W]),
      .ns_i(txn_ns_i[f]), .wr_i(txn_write_i[f]),
      .id_i(txn_id_i[f*ID_W +: ID_W]),
      .allow_o(allow_c[f])
    );
  end

  assign deny = txn_valid_i & ~allow_c;
  assign clr  = (reg_we_i && reg_addr_i == RA_ICLR) ? reg_wdata_i[NUM_FILTERS-1:0] : '0;

  rsf_fail_capture #(
    .NUM_FILTERS(NUM_FILTERS), .ADDR_W(ADDR_W), .ID_W(ID_W)
  ) u_fail (
    .clk_i, .rst_ni,
    .deny_i(deny), .action_i(action), .clr_i(clr),
    .addr_i(txn_addr_i), .id_i(txn_id_i),
    .ns_i(txn_ns_i), .priv_i(txn_priv_i), .wr_i(txn_write_i),
    .raddr_i(reg_addr_i), .status_o(status), .rdata_o(rd_fail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= '0;
      resp_allow_o <= '0;
      resp_err_o   <= '0;
    end else begin
      resp_valid_o <= txn_valid_i;
      resp_allow_o <= txn_valid_i & allow_c;
      resp_err_o   <= deny & {NUM_FILTERS{action[0]}};
    end
  end

  assign reg_rdata_o = rd_reg | rd_fail;
  assign irq_o       = |status;

  // R8: an error is only ever raised on a valid, refused access
  a_r8_err_on_deny: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|resp_err_o) |-> ((resp_err_o & ~(resp_valid_o & ~resp_allow_o)) == '0));
  // R8: responses follow presented transactions by one cycle
  a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|resp_valid_o) |-> ((resp_valid_o & ~$past(txn_valid_i)) == '0));
  // R9: the interrupt line rises together with a refused response
  a_r9_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (|(resp_valid_o & ~resp_allow_o)));
endmodule

// File: tb/tb_region_sec_filter.sv
module tb_region_sec_filter;
  localparam int NF = 4, NR = 9, AW = 40, IW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, reg_we;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [NF-1:0] txn_valid, txn_ns, txn_priv, txn_write;
  logic [NF*AW-1:0] txn_addr;
  logic [NF*IW-1:0] txn_id;
  logic [NF-1:0] resp_valid, resp_allow, resp_err;
  logic irq;

  region_sec_filter #(.NUM_FILTERS(NF), .NUM_REGIONS(NR), .ADDR_W(AW), .ID_W(IW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .txn_valid_i(txn_valid),
    .txn_addr_i(txn_addr), .txn_ns_i(txn_ns), .txn_priv_i(txn_priv),
    .txn_write_i(txn_write), .txn_id_i(txn_id), .resp_valid_o(resp_valid),
    .resp_allow_o(resp_allow), .resp_err_o(resp_err), .irq_o(irq));

  int errors = 0, checks = 0;

  // model
  logic [39:0] m_base[4], m_top[4];
  logic [3:0]  m_fen[4];
  logic [1:0]  m_sec[4];
  logic [31:0] m_idp[4];
  logic [1:0]  m_act;
  logic [3:0]  m_st;
  logic [39:0] m_caddr[4];
  logic [3:0]  m_cid[4];
  logic [2:0]  m_cctl[4];

  // stimulus
  logic [3:0]  t_v;
  logic [39:0] t_a[4];
  logic        t_ns[4], t_pr[4], t_wr[4];
  logic [3:0]  t_id[4];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_allow(int f, logic [39:0] a, bit ns, bit wr, logic [3:0] id);
    int sel = 0;
    for (int r = 1; r < 4; r++)
      if (m_fen[r][f] && a[39:12] >= m_base[r][39:12] && a[39:12] <= m_top[r][39:12]) sel = r;
    if (!ns) return wr ? m_sec[sel][1] : m_sec[sel][0];
    return m_idp[sel][{wr, id}];
  endfunction

  function automatic logic [39:0] pick(int k);
    case (k)
      0: return 40'h0FFF;        1: return 40'h1000;
      2: return 40'h2FFF;        3: return 40'h3000;
      4: return 40'h3FFF;        5: return 40'h4000;
      6: return 40'h4FFF;        7: return 40'h5000;
      8: return 40'h11_FFFF_FFFF; 9: return 40'h12_0000_0000;
      10: return 40'h12_0000_FFFF; 11: return 40'h12_0001_0000;
      default: return {8'($urandom), 32'($urandom)};
    endcase
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_action(logic [1:0] a);
    wr(8'h01, {30'b0, a});
    m_act = a;
  endtask

  task automatic clear(logic [3:0] m);
    wr(8'h03, {28'b0, m});
    m_st = m_st & ~m;
  endtask

  task automatic cfg_region(int r, logic [39:0] b, logic [39:0] t, logic [3:0] fe,
                            logic [1:0] s, logic [31:0] ip);
    logic [7:0] base = 8'(8'h40 + 8 * r);
    wr(base + 8'd0, b[31:0]);
    wr(base + 8'd1, 32'(b[39:32]));
    wr(base + 8'd2, t[31:0]);
    wr(base + 8'd3, 32'(t[39:32]));
    wr(base + 8'd4, {s, 26'b0, fe});
    wr(base + 8'd5, ip);
    m_sec[r] = s; m_idp[r] = ip;
    if (r != 0) begin
      m_base[r] = {b[39:12], 12'h000};
      m_top[r]  = {t[39:12], 12'hFFF};
      m_fen[r]  = fe;
    end
  endtask

  task automatic fire(string req);
    bit e[4];
    @(negedge clk);
    for (int f = 0; f < NF; f++) begin
      txn_valid[f] = t_v[f];
      txn_addr[f*AW +: AW] = t_a[f];
      txn_ns[f] = t_ns[f]; txn_priv[f] = t_pr[f]; txn_write[f] = t_wr[f];
      txn_id[f*IW +: IW] = t_id[f];
      e[f] = exp_allow(f, t_a[f], t_ns[f], t_wr[f], t_id[f]);
    end
    @(negedge clk);
    txn_valid = '0;
    for (int f = 0; f < NF; f++) begin
      if (t_v[f]) begin
        chk({req, " R8 valid"}, 64'(resp_valid[f]), 64'd1);
        chk({req, " R6 R7 allow"}, 64'(resp_allow[f]), 64'(e[f]));
        chk({req, " R8 err"}, 64'(resp_err[f]), 64'(!e[f] && m_act[0]));
        if (!e[f]) begin
          if (!m_st[f]) begin
            m_caddr[f] = t_a[f]; m_cid[f] = t_id[f];
            m_cctl[f] = {t_wr[f], t_pr[f], t_ns[f]};
          end
          if (m_act[1]) m_st[f] = 1'b1;
        end
      end else begin
        chk({req, " R8 idle"}, 64'(resp_valid[f]), 64'd0);
      end
    end
    chk({req, " R9 irq"}, 64'(irq), 64'(|m_st));
  endtask

  task automatic one(int f, logic [39:0] a, bit ns, bit w, logic [3:0] id, bit pr, string req);
    t_v = 4'(1 << f);
    t_a[f] = a; t_ns[f] = ns; t_wr[f] = w; t_id[f] = id; t_pr[f] = pr;
    fire(req);
  endtask

  task automatic chk_fail(int f, string req);
    logic [31:0] d;
    logic [7:0] b = 8'(8'h10 + 4 * f);
    rd(b, d);         chk({req, " R11 addr lo"}, 64'(d), 64'(m_caddr[f][31:0]));
    rd(b + 8'd1, d);  chk({req, " R11 addr hi"}, 64'(d), 64'(m_caddr[f][39:32]));
    rd(b + 8'd2, d);  chk({req, " R11 id"}, 64'(d), 64'(m_cid[f]));
    rd(b + 8'd3, d);  chk({req, " R11 ctl"}, 64'(d), 64'(m_cctl[f]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit seen[4];
    void'($urandom(32'd1234));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    txn_valid = '0; txn_addr = '0; txn_ns = '0; txn_priv = '0; txn_write = '0; txn_id = '0;
    t_v = '0;
    for (int f = 0; f < 4; f++) begin
      t_a[f] = '0; t_ns[f] = 0; t_pr[f] = 0; t_wr[f] = 0; t_id[f] = '0;
      m_caddr[f] = '0; m_cid[f] = '0; m_cctl[f] = '0; seen[f] = 0;
      m_base[f] = '0; m_top[f] = '0; m_fen[f] = '0; m_sec[f] = '0; m_idp[f] = '0;
    end
    m_top[0] = '1; m_fen[0] = 4'hF; m_act = 2'd0; m_st = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 resp_valid", 64'(resp_valid), 64'd0);
    chk("R1 irq", 64'(irq), 64'd0);
    rd(8'h02, d); chk("R1 status", 64'(d), 64'd0);
    rd(8'h01, d); chk("R1 action", 64'(d), 64'd0);

    // R2 build word
    rd(8'h00, d); chk("R2 build", 64'(d), 64'h0300_2708);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R2 build read-only", 64'(d), 64'h0300_2708);

    // regions
    cfg_region(0, 40'h5000, 40'h0, 4'h0, 2'b01, 32'h0000_0002);
    cfg_region(1, 40'h1234, 40'h4000, 4'b0011, 2'b11, 32'h0008_0004);
    cfg_region(2, 40'h3000, 40'h3FFF, 4'b1111, 2'b00, 32'h0020_0020);
    cfg_region(3, 40'h12_0000_0000, 40'h12_0000_FFFF, 4'b1000, 2'b10, 32'h0);

    // R3 readback granularity
    rd(8'h48, d); chk("R3 base lo", 64'(d), 64'h1000);
    rd(8'h4A, d); chk("R3 top lo", 64'(d), 64'h4FFF);
    rd(8'h59, d); chk("R3 base hi", 64'(d), 64'h12);
    rd(8'h5B, d); chk("R3 top hi", 64'(d), 64'h12);
    rd(8'h4C, d); chk("R5 attr", 64'(d), 64'hC000_0003);

    // R12 background region
    rd(8'h40, d); chk("R12 base lo", 64'(d), 64'h0);
    rd(8'h42, d); chk("R12 top lo", 64'(d), 64'hFFFF_FFFF);
    rd(8'h43, d); chk("R12 top hi", 64'(d), 64'hFF);
    rd(8'h44, d); chk("R12 attr", 64'(d), 64'h4000_000F);

    set_action(2'd3);
    // R4 priority
    one(0, 40'h3000, 0, 0, 0, 0, "R4 region2 over region1");
    one(0, 40'h2000, 0, 0, 0, 0, "R4 region1");
    one(0, 40'h9000, 0, 1, 0, 0, "R4 background");
    // R5 filter bitmap
    one(2, 40'h2000, 0, 0, 0, 0, "R5 not mapped read");
    one(2, 40'h2000, 0, 1, 0, 0, "R5 not mapped write");
    // R6 R7 edges
    one(1, 40'h4FFF, 1, 1, 3, 0, "R7 id write at top");
    one(1, 40'h5000, 1, 0, 1, 0, "R7 id read background");
    one(3, 40'h12_0000_FFFF, 0, 1, 0, 0, "R6 secure write");
    clear(4'hF);

    // R8 action encodings
    set_action(2'd1);
    one(0, 40'h3000, 0, 0, 0, 0, "R8 error only");
    rd(8'h02, d); chk("R8 no status", 64'(d), 64'd0);
    set_action(2'd2);
    one(0, 40'h3000, 0, 0, 0, 0, "R8 irq only");
    rd(8'h02, d); chk("R9 status", 64'(d), 64'd1);
    set_action(2'd0);
    one(1, 40'h3000, 0, 0, 0, 0, "R8 none");
    rd(8'h02, d); chk("R9 status none", 64'(d), 64'd1);

    // R10 selective clear
    set_action(2'd3);
    one(1, 40'h3000, 0, 0, 0, 0, "R10 setup");
    clear(4'b0001);
    rd(8'h02, d); chk("R10 selective clear", 64'(d), 64'b0010);
    chk("R10 irq", 64'(irq), 64'd1);
    clear(4'hF);
    chk("R10 irq low", 64'(irq), 64'd0);

    // R11 first record held
    one(3, 40'h12_0000_0010, 1, 0, 4'd7, 1, "R11 first");
    one(3, 40'h5000, 0, 1, 4'd2, 0, "R11 second");
    rd(8'h1C, d); chk("R11 held addr", 64'(d), 64'h10);
    rd(8'h1F, d); chk("R11 held ctl", 64'(d), 64'b011);
    chk_fail(3, "R11 model");
    clear(4'hF);
    one(3, 40'h5000, 0, 1, 4'd2, 0, "R11 after clear");
    rd(8'h1C, d); chk("R11 new addr", 64'(d), 64'h5000);
    clear(4'hF);

    // random mix
    for (int it = 0; it < 400; it++) begin
      t_v = 4'($urandom);
      for (int f = 0; f < NF; f++) begin
        t_a[f] = pick(int'($urandom % 16));
        t_ns[f] = 1'($urandom); t_wr[f] = 1'($urandom);
        t_pr[f] = 1'($urandom); t_id[f] = 4'($urandom);
        if (t_v[f] && !exp_allow(f, t_a[f], t_ns[f], t_wr[f], t_id[f])) seen[f] = 1;
      end
      fire("R6 R7 random");
      if (it % 40 == 39) begin
        for (int f = 0; f < NF; f++) if (seen[f]) chk_fail(f, "random");
        rd(8'h02, d); chk("R9 random status", 64'(d), 64'(m_st));
        clear(4'hF);
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule